// File: doc/BRIEF.md
# Programmable Chip-Select Unit

This block turns bus addresses into four active-low select strobes for external memories and peripherals. Each select has a base address, an ignore mask, an enable, a port-width flag and a wait-state count, all loaded through a small register port. Selects 0 and 1 are general-purpose memory selects that can also refuse writes. Selects 2 and 3 serve the disk and media-card path. They decode addresses and insert wait states in the same way, but they carry no write protection and always present a 16-bit port.

A bus cycle opens with a one-clock start strobe that carries the address and the direction. One clock later the unit drives the select that won the decode. It counts the programmed wait states and then pulses transfer-acknowledge low for one clock. On the clock after that pulse the select is released. A cycle that no select claims, or a write into a write-protected region, drives no select and raises a one-clock error pulse instead.

Select 0 comes out of reset already live. It covers the whole address space, refuses writes, uses a 16-bit port and runs with the longest wait, so a processor can fetch boot code from slow external flash before any register has been written.

Top module: `cs_unit`

## Requirements
- R1: After reset all selects are high, acknowledge is high and error is low. The control register of select 0 reads 0xF7, that of select 1 reads 0x00, and those of selects 2 and 3 read 0x04. A read at any address then drives select 0 with 15 wait states.
- R2: A select matches when the address equals its base on every bit where its mask bit is 0. Mask bits set to 1 are ignored. The register index is cfg_reg: 0 is base, 1 is mask, 2 is control.
- R3: When several enabled selects match, only the lowest-numbered one is driven.
- R4: A select whose control bit 0 (enable) is 0 is never driven, even if its address matches.
- R5: Acknowledge goes low exactly N+1 clocks after the select goes low, where N is control bits [7:4]. It stays low for one clock, and the select is released on the following clock.
- R6: A write to a general select whose control bit 1 (read-only) is set drives no select and no acknowledge, and pulses the error output for one clock, one clock after the start strobe.
- R7: A cycle that no enabled select matches pulses the error output for one clock and drives no select.
- R8: At most one select is low at any time.
- R9: Output port16 is high while a select is driven whose control bit 2 is set, and it is low when no select is driven.
- R10: Selects 2 and 3 accept writes whatever is written to bit 1, and always act as 16-bit ports. Their control register reads back bit 1 as 0 and bit 2 as 1.
- R11: A start strobe that arrives while a cycle is in progress is ignored. The active select holds until its acknowledge, and no new cycle follows.
- R12: The control register reads back enable in bit 0, read-only in bit 1, port width in bit 2 and wait count in bits [7:4]. Base and mask read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Select index for register access |
| cfg_reg | input | 2 | Register index: 0 base, 1 mask, 2 control |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| bus_start | input | 1 | One-clock strobe that opens a bus cycle |
| bus_addr | input | 32 | Cycle address, valid with bus_start |
| bus_write | input | 1 | 1 for a write cycle, valid with bus_start |
| cs_n | output | 4 | Active-low select outputs |
| ta_n | output | 1 | Active-low transfer acknowledge |
| bus_err | output | 1 | One-clock error pulse for a refused or unclaimed cycle |
| port16 | output | 1 | High when the driven select is a 16-bit port |

## Verification
The hardest case to reach is a start strobe that arrives in the middle of a wait-state countdown. From the ports it looks like a new cycle request, and a wrong design would retarget the select or chain a second cycle. The stimulus programs select 2 with five wait states and opens a cycle on it. While that cycle counts down, the bench pulses start for several clocks with an address that select 0 claims. It then checks that select 2 stays low until its acknowledge and that every select stays high for several clocks after the release. Overlapping windows are built on purpose so that one address matches two selects.

// File: rtl/cs_pkg.sv
// Shared encodings for the chip-select unit: register indices, control
// field positions and the bus-cycle state type. Assumes control fields fit
// inside the configuration data word.
package cs_pkg;
    localparam logic [1:0] REG_BASE = 2'd0;
    localparam logic [1:0] REG_MASK = 2'd1;
    localparam logic [1:0] REG_CTRL = 2'd2;

    localparam int CTL_EN       = 0;
    localparam int CTL_RO       = 1;
    localparam int CTL_P16      = 2;
    localparam int CTL_WAIT_LSB = 4;

    typedef enum logic [1:0] {
        CYC_IDLE = 2'd0,
        CYC_WAIT = 2'd1,
        CYC_ACK  = 2'd2
    } cyc_state_t;
endpackage

// File: rtl/cs_regfile.sv
// Configuration storage for every select: base, ignore mask and control.
// Selects below NUM_GP are general-purpose (write protection and port width
// programmable). The rest are dedicated media selects with protection
// forced off and the port width forced to 16 bits. Select 0 resets to a live
// boot window. Assumes ADDR_W >= CTL_WAIT_LSB + WAIT_W.
module cs_regfile
    import cs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NUM_CS = 4,
    parameter int NUM_GP = 2,
    parameter int WAIT_W = 4,
    localparam int SEL_W = $clog2(NUM_CS)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_we,
    input  logic [SEL_W-1:0]                   cfg_sel,
    input  logic [1:0]                         cfg_reg,
    input  logic [ADDR_W-1:0]                  cfg_wdata,
    output logic [ADDR_W-1:0]                  cfg_rdata,
    output logic [NUM_CS-1:0][ADDR_W-1:0]      base_o,
    output logic [NUM_CS-1:0][ADDR_W-1:0]      mask_o,
    output logic [NUM_CS-1:0]                  en_o,
    output logic [NUM_CS-1:0]                  ro_o,
    output logic [NUM_CS-1:0]                  p16_o,
    output logic [NUM_CS-1:0][WAIT_W-1:0]      wait_o
);
    localparam int WAIT_MSB = CTL_WAIT_LSB + WAIT_W - 1;

    for (genvar i = 0; i < NUM_CS; i++) begin : g_sel
        localparam bit IS_BOOT = (i == 0);
        logic hit_wr;
        assign hit_wr = cfg_we && (cfg_sel == SEL_W'(i));

        // Base, mask, enable and wait count: common to every select.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_o[i] <= '0;
                mask_o[i] <= IS_BOOT ? '1 : '0;
                en_o[i]   <= IS_BOOT;
                wait_o[i] <= IS_BOOT ? '1 : '0;
            end else if (hit_wr) begin
                if (cfg_reg == REG_BASE) base_o[i] <= cfg_wdata;
                if (cfg_reg == REG_MASK) mask_o[i] <= cfg_wdata;
                if (cfg_reg == REG_CTRL) begin
                    en_o[i]   <= cfg_wdata[CTL_EN];
                    wait_o[i] <= cfg_wdata[WAIT_MSB:CTL_WAIT_LSB];
                end
            end
        end

        if (i < NUM_GP) begin : g_general
            // Write protection and port width: programmable on general selects.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ro_o[i]  <= IS_BOOT;
                    p16_o[i] <= IS_BOOT;
                end else if (hit_wr && cfg_reg == REG_CTRL) begin
                    ro_o[i]  <= cfg_wdata[CTL_RO];
                    p16_o[i] <= cfg_wdata[CTL_P16];
                end
            end
        end else begin : g_media
            // Media selects: never protected, always 16-bit.
            assign ro_o[i]  = 1'b0;
            assign p16_o[i] = 1'b1;
        end
    end

    // Register read-back multiplexer.
    always_comb begin
        cfg_rdata = '0;
        case (cfg_reg)
            REG_BASE: cfg_rdata = base_o[cfg_sel];
            REG_MASK: cfg_rdata = mask_o[cfg_sel];
            REG_CTRL: begin
                cfg_rdata[CTL_EN]                = en_o[cfg_sel];
                cfg_rdata[CTL_RO]                = ro_o[cfg_sel];
                cfg_rdata[CTL_P16]               = p16_o[cfg_sel];
                cfg_rdata[WAIT_MSB:CTL_WAIT_LSB] = wait_o[cfg_sel];
            end
            default: cfg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cs_decode.sv
// Combinational address decode: per-select masked compare, fixed priority
// to the lowest index, and a write-protection verdict for the winner.
// Assumes the caller samples the result only together with a start strobe.
module cs_decode #(
    parameter int ADDR_W = 32,
    parameter int NUM_CS = 4
) (
    input  logic [ADDR_W-1:0]             addr,
    input  logic                          write,
    input  logic [NUM_CS-1:0][ADDR_W-1:0] base,
    input  logic [NUM_CS-1:0][ADDR_W-1:0] mask,
    input  logic [NUM_CS-1:0]             en,
    input  logic [NUM_CS-1:0]             ro,
    output logic [NUM_CS-1:0]             grant,
    output logic                          any_hit,
    output logic                          deny
);
    logic [NUM_CS-1:0] match;

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cmp
        // Masked compare of one select's window.
        assign match[i] = en[i] && (((addr ^ base[i]) & ~mask[i]) == '0);
    end

    // Lowest-numbered matching select wins.
    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (match[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end

    assign any_hit = |match;
    assign deny    = write && |(grant & ro);
endmodule

// File: rtl/cs_cycle_ctrl.sv
// Bus-cycle sequencer: accepts a start strobe when idle, drives the granted
// select, counts the wait states, pulses acknowledge for one clock, then
// releases. Refused or unclaimed cycles give a one-clock error pulse.
// Assumes grant is onehot0 and valid in the start-strobe cycle.
module cs_cycle_ctrl
    import cs_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int WAIT_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_start,
    input  logic [NUM_CS-1:0]             grant,
    input  logic                          any_hit,
    input  logic                          deny,
    input  logic [NUM_CS-1:0][WAIT_W-1:0] wait_cnt,
    input  logic [NUM_CS-1:0]             p16,
    output logic [NUM_CS-1:0]             cs_n,
    output logic                          ta_n,
    output logic                          bus_err,
    output logic                          port16
);
    cyc_state_t        state;
    logic [WAIT_W-1:0] cnt;
    logic [WAIT_W-1:0] wait_sel;
    logic              p16_sel;

    // Pick wait count and port width of the granted select.
    always_comb begin
        wait_sel = '0;
        p16_sel  = 1'b0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (grant[i]) begin
                wait_sel = wait_sel | wait_cnt[i];
                p16_sel  = p16_sel | p16[i];
            end
        end
    end

    // Cycle state, wait counter and registered bus outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= CYC_IDLE;
            cnt     <= '0;
            cs_n    <= '1;
            ta_n    <= 1'b1;
            bus_err <= 1'b0;
            port16  <= 1'b0;
        end else begin
            bus_err <= 1'b0;
            case (state)
                CYC_IDLE: begin
                    if (bus_start) begin
                        if (any_hit && !deny) begin
                            cs_n   <= ~grant;
                            port16 <= p16_sel;
                            cnt    <= wait_sel;
                            state  <= CYC_WAIT;
                        end else begin
                            bus_err <= 1'b1;
                        end
                    end
                end
                CYC_WAIT: begin
                    if (cnt == '0) begin
                        ta_n  <= 1'b0;
                        state <= CYC_ACK;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                CYC_ACK: begin
                    ta_n   <= 1'b1;
                    cs_n   <= '1;
                    port16 <= 1'b0;
                    state  <= CYC_IDLE;
                end
                default: state <= CYC_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cs_unit.sv
// Top of the programmable chip-select unit: configuration registers,
// address decode and bus-cycle sequencer. Select 0 is live from reset as
// a boot window. Assumes one bus cycle at a time, opened by bus_start.
module cs_unit #(
    parameter int ADDR_W = 32,
    parameter int NUM_CS = 4,
    parameter int NUM_GP = 2,
    parameter int WAIT_W = 4,
    localparam int SEL_W = $clog2(NUM_CS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [1:0]        cfg_reg,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    input  logic              bus_start,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_write,
    output logic [NUM_CS-1:0] cs_n,
    output logic              ta_n,
    output logic              bus_err,
    output logic              port16
);
    logic [NUM_CS-1:0][ADDR_W-1:0] base;
    logic [NUM_CS-1:0][ADDR_W-1:0] mask;
    logic [NUM_CS-1:0]             en;
    logic [NUM_CS-1:0]             ro;
    logic [NUM_CS-1:0]             p16;
    logic [NUM_CS-1:0][WAIT_W-1:0] wait_cnt;
    logic [NUM_CS-1:0]             grant;
    logic                          any_hit;
    logic                          deny;

    cs_regfile #(
        .ADDR_W(ADDR_W), .NUM_CS(NUM_CS), .NUM_GP(NUM_GP), .WAIT_W(WAIT_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_reg(cfg_reg), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .base_o(base), .mask_o(mask), .en_o(en), .ro_o(ro), .p16_o(p16),
        .wait_o(wait_cnt)
    );

    cs_decode #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS)) u_dec (
        .addr(bus_addr), .write(bus_write), .base(base), .mask(mask),
        .en(en), .ro(ro), .grant(grant), .any_hit(any_hit), .deny(deny)
    );

    cs_cycle_ctrl #(.NUM_CS(NUM_CS), .WAIT_W(WAIT_W)) u_cyc (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .grant(grant),
        .any_hit(any_hit), .deny(deny), .wait_cnt(wait_cnt), .p16(p16),
        .cs_n(cs_n), .ta_n(ta_n), .bus_err(bus_err), .port16(port16)
    );
endmodule

// File: rtl/cs_unit_chk.sv
// Protocol checker for the chip-select outputs, bound into cs_unit.
module cs_unit_chk #(
    parameter int NUM_CS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CS-1:0] cs_n,
    input logic              ta_n,
    input logic              bus_err,
    input logic              port16
);
    // R8
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R5
    ta_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ta_n |-> (cs_n != '1));

    // R5
    ta_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ta_n |=> (ta_n && cs_n == '1));

    // R6
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (cs_n == '1 && ta_n));

    // R11
    cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n != '1 && ta_n) |=> (cs_n == $past(cs_n)));

    // R9
    p16_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n == '1) |-> !port16);
endmodule

bind cs_unit cs_unit_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ta_n(ta_n),
    .bus_err(bus_err), .port16(port16)
);

// File: tb/cs_unit_tb.sv
`timescale 1ns/1ps
module cs_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [1:0]  cfg_reg = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        bus_start = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_write = 1'b0;
    logic [3:0]  cs_n;
    logic        ta_n;
    logic        bus_err;
    logic        port16;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    cs_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_reg(cfg_reg), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .bus_start(bus_start), .bus_addr(bus_addr), .bus_write(bus_write),
        .cs_n(cs_n), .ta_n(ta_n), .bus_err(bus_err), .port16(port16)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input [1:0] s, input [1:0] r, input [31:0] d);
        @(negedge clk);
        cfg_sel = s; cfg_reg = r; cfg_wdata = d; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input [1:0] s, input [1:0] r, output [31:0] d);
        @(negedge clk);
        cfg_sel = s; cfg_reg = r;
        #1 d = cfg_rdata;
    endtask

    // One bus cycle; reports select seen, error, acknowledge delay, width, release.
    task automatic run_cycle(input [31:0] a, input bit w, output [3:0] cs_seen,
                             output bit err_seen, output int waits,
                             output bit p16_seen, output bit released);
        @(negedge clk);
        bus_addr = a; bus_write = w; bus_start = 1'b1;
        @(negedge clk);
        bus_start = 1'b0;
        cs_seen = cs_n; err_seen = bus_err; p16_seen = port16;
        waits = -1; released = 1'b1;
        if (cs_seen != 4'hF) begin
            for (int k = 1; k <= 40; k++) begin
                @(negedge clk);
                if (!ta_n) begin waits = k; break; end
            end
            @(negedge clk);
            released = (cs_n == 4'hF) && ta_n;
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk(cs_n == 4'hF && ta_n && !bus_err && !port16, "R1", "idle outputs",
            {cs_n, ta_n, bus_err, port16}, 7'b1111100);
        cfg_read(2'd0, 2'd2, d); chk(d == 32'hF7, "R1", "sel0 ctrl", d, 32'hF7);
        cfg_read(2'd1, 2'd2, d); chk(d == 32'h00, "R1", "sel1 ctrl", d, 32'h00);
        cfg_read(2'd2, 2'd2, d); chk(d == 32'h04, "R1", "sel2 ctrl", d, 32'h04);
        cfg_read(2'd3, 2'd2, d); chk(d == 32'h04, "R1", "sel3 ctrl", d, 32'h04);
    endtask

    task automatic t_boot;
        logic [3:0] c; bit e, p, r; int wt;
        run_cycle(32'h1234_5678, 1'b0, c, e, wt, p, r);
        chk(c == 4'b1110 && !e, "R1", "boot read select", c, 4'b1110);
        chk(wt == 16, "R5", "boot wait", wt, 16);
        chk(p, "R9", "boot port16", p, 1);
        chk(r, "R5", "release after ack", r, 1);
        run_cycle(32'h0000_0100, 1'b1, c, e, wt, p, r);
        chk(c == 4'hF && e, "R6", "write to read-only", {c, e}, 5'b11111);
        @(negedge clk);
        chk(!bus_err, "R6", "error one clock", bus_err, 0);
    endtask

    task automatic t_windows;
        logic [3:0] c; bit e, p, r; int wt; logic [31:0] d;
        cfg_write(2'd0, 2'd1, 32'h0000_FFFF);
        cfg_write(2'd0, 2'd2, 32'h07);
        run_cycle(32'h0000_0010, 1'b0, c, e, wt, p, r);
        chk(c == 4'b1110 && wt == 1, "R5", "sel0 zero wait", wt, 1);
        run_cycle(32'h0001_0000, 1'b0, c, e, wt, p, r);
        chk(c == 4'hF && e, "R2", "outside sel0 mask", {c, e}, 5'b11111);
        cfg_write(2'd1, 2'd0, 32'h4000_0000);
        cfg_write(2'd1, 2'd1, 32'h00FF_FFFF);
        cfg_write(2'd1, 2'd2, 32'h21);
        cfg_read(2'd1, 2'd1, d); chk(d == 32'h00FF_FFFF, "R12", "sel1 mask", d, 32'h00FF_FFFF);
        cfg_read(2'd1, 2'd2, d); chk(d == 32'h21, "R12", "sel1 ctrl", d, 32'h21);
        run_cycle(32'h40AB_CDEF, 1'b1, c, e, wt, p, r);
        chk(c == 4'b1101 && !e, "R2", "sel1 write", c, 4'b1101);
        chk(wt == 3, "R5", "sel1 wait", wt, 3);
        chk(!p, "R9", "sel1 32-bit", p, 0);
        run_cycle(32'h4100_0000, 1'b0, c, e, wt, p, r);
        chk(c == 4'hF && e, "R7", "unclaimed", {c, e}, 5'b11111);
    endtask

    task automatic t_media;
        logic [3:0] c; bit e, p, r; int wt; logic [31:0] d;
        cfg_write(2'd2, 2'd0, 32'h4000_0000);
        cfg_write(2'd2, 2'd1, 32'h0FFF_FFFF);
        cfg_write(2'd2, 2'd2, 32'h53);
        cfg_read(2'd2, 2'd2, d); chk(d == 32'h55, "R10", "sel2 ctrl", d, 32'h55);
        run_cycle(32'h4000_0010, 1'b0, c, e, wt, p, r);
        chk(c == 4'b1101, "R3", "overlap lowest wins", c, 4'b1101);
        run_cycle(32'h4800_0000, 1'b1, c, e, wt, p, r);
        chk(c == 4'b1011 && !e, "R10", "sel2 write allowed", {c, e}, 5'b10110);
        chk(wt == 6 && p, "R10", "sel2 wait/16-bit", wt, 6);
        cfg_write(2'd3, 2'd0, 32'h8000_0000);
        cfg_write(2'd3, 2'd1, 32'h0);
        cfg_write(2'd3, 2'd2, 32'h01);
        run_cycle(32'h8000_0000, 1'b0, c, e, wt, p, r);
        chk(c == 4'b0111 && wt == 1 && p, "R2", "sel3 exact", c, 4'b0111);
        run_cycle(32'h8000_0004, 1'b0, c, e, wt, p, r);
        chk(c == 4'hF && e, "R2", "sel3 one bit off", {c, e}, 5'b11111);
    endtask

    task automatic t_disable;
        logic [3:0] c; bit e, p, r; int wt;
        cfg_write(2'd1, 2'd2, 32'h20);
        run_cycle(32'h4000_0010, 1'b0, c, e, wt, p, r);
        chk(c == 4'b1011, "R4", "disabled sel1 skipped", c, 4'b1011);
    endtask

    task automatic t_busy;
        int ack_at = -1;
        bit hold_ok = 1'b1;
        bit quiet = 1'b1;
        @(negedge clk);
        bus_addr = 32'h4800_0000; bus_write = 1'b0; bus_start = 1'b1;
        @(negedge clk);
        bus_addr = 32'h0000_0000;
        for (int k = 1; k <= 12; k++) begin
            if (k == 4) bus_start = 1'b0;
            @(negedge clk);
            if (!ta_n && ack_at < 0) ack_at = k;
            if (ack_at < 0 && cs_n != 4'b1011) hold_ok = 1'b0;
            if (ack_at > 0 && k > ack_at && cs_n != 4'hF) quiet = 1'b0;
        end
        bus_start = 1'b0;
        chk(hold_ok, "R11", "select held", hold_ok, 1);
        chk(ack_at == 6, "R11", "ack timing under strobes", ack_at, 6);
        chk(quiet, "R11", "no chained cycle", quiet, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_boot();
        t_windows();
        t_media();
        t_disable();
        t_busy();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule